// File: doc/BRIEF.md
# Dual-Format Parallel-to-Serial Transmitter

This block takes 8b/10b code groups from a protocol device and sends them out one bit per serial clock, first bit first. It runs entirely on the serial bit clock. Two strobes mark the edges of the slower reference clock: a word strobe, one cycle in ten, marks the rising edge, and a half strobe, five cycles later, marks the falling edge. A format input picks how the parallel side is read. In full-width format a whole 10-bit group is taken on the word strobe. In half-width format only the low five data inputs are used. Code bits 0..4 are taken on the word strobe and code bits 5..9 on the half strobe that follows. The two halves are then merged into one 10-bit group.

The serial side holds a shift register. It reloads on every word strobe and shifts toward bit 0 on every other cycle, so one group leaves per reference period. A loopback input sends the stream to an internal tap that feeds the receiver and takes the external drive off the line. A low enable idles the block and releases every output.

Top module: `pser_tx`

## Requirements
- R1: After reset, `ser_oe`, `ser_dat` and `loop_dat` are all 0 until the first word strobe is taken.
- R2: In full-width format (`fmt_sel`=0), the 10-bit `td` value taken at a word strobe appears on the serial output bit 0 first. Bit j is present in the cycle that follows the (10+j)-th clock edge after the capturing edge.
- R3: In full-width format, bit 9 of a group leaves 19 bit times after the edge that captured it.
- R4: In half-width format (`fmt_sel`=1), code bits 0..4 are `td[4:0]` at the word strobe and code bits 5..9 are `td[4:0]` at the following half strobe. `td[9:5]` has no effect.
- R5: In half-width format, bit 9 of a group leaves 29 bit times after its word-strobe capture edge, which means bit j is present after edge 20+j.
- R6: On cycles without a word strobe, the shift register moves one place toward bit 0 and fills with 0. After all ten bits have gone, the output stays 0 until the next load.
- R7: `ser_oe` stays 0 after reset, or after the block has been idled, until a word strobe loads the shift register. From then on it is 1 while `en`=1 and `loop_en`=0.
- R8: With `loop_en`=1, the stream appears on `loop_dat`, and `ser_oe` and `ser_dat` are 0. With `loop_en`=0, `loop_dat` is 0.
- R9: With `en`=0, all outputs are 0 and all stored words are cleared. After `en` returns to 1, R7 applies again.
- R10: In full-width format, the half strobe and the `td` value present at it have no effect on the stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en | input | 1 | Block enable; low idles the block and releases outputs |
| fmt_sel | input | 1 | 0 = full-width 10-bit capture, 1 = half-width double-edge capture |
| loop_en | input | 1 | Route the stream to the internal receiver tap |
| word_stb | input | 1 | Reference rising-edge marker, one cycle in ten |
| half_stb | input | 1 | Reference falling-edge marker, five cycles after `word_stb` |
| td | input | 10 | Parallel code-group input |
| ser_dat | output | 1 | External serial data, 0 while not driven |
| ser_oe | output | 1 | External serial output enable |
| loop_dat | output | 1 | Internal loopback serial data |

## Verification
The checks assume the two strobes are never high in the same cycle. They also assume the word strobe comes exactly every ten cycles, with the half strobe five cycles after it, except for deliberate gaps. Format changes are assumed only at group boundaries. The stimulus builds every frame from a fixed ten-cycle schedule and fills the unused `td` bits and off-strobe cycles with random values. It pauses the strobes only in a directed gap test. After each format, loopback or enable change, it skips data comparison until the pipeline has refilled.

// File: rtl/ptx_pkg.sv
package ptx_pkg;
  typedef enum logic {
    FMT_FULL = 1'b0,
    FMT_HALF = 1'b1
  } fmt_e;
endpackage

// File: rtl/ptx_capture.sv
module ptx_capture
  import ptx_pkg::*;
#(
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  fmt_e              fmt_i,
  input  logic              word_stb_i,
  input  logic              half_stb_i,
  input  logic [WORD_W-1:0] td_i,
  output logic [WORD_W-1:0] word_o
);
  localparam int HALF_W = WORD_W / 2;

  logic [WORD_W-1:0] full_q, full_d;
  logic [HALF_W-1:0] lo_q, lo_d;
  logic [HALF_W-1:0] hi_q, hi_d;
  logic [WORD_W-1:0] pair_q, pair_d;

  // next-state: full-width capture on the rising-edge marker
  always_comb begin
    full_d = full_q;
    if (!run_i)                                full_d = '0;
    else if (word_stb_i && fmt_i == FMT_FULL)  full_d = td_i;
  end

  // next-state: half-width capture and assembly
  always_comb begin
    lo_d   = lo_q;
    hi_d   = hi_q;
    pair_d = pair_q;
    if (!run_i) begin
      lo_d   = '0;
      hi_d   = '0;
      pair_d = '0;
    end else if (fmt_i == FMT_HALF) begin
      if (word_stb_i) begin
        lo_d   = td_i[HALF_W-1:0];
        pair_d = {hi_q, lo_q};
      end
      if (half_stb_i) hi_d = td_i[HALF_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
      pair_q <= '0;
    end else begin
      full_q <= full_d;
      lo_q   <= lo_d;
      hi_q   <= hi_d;
      pair_q <= pair_d;
    end
  end

  assign word_o = (fmt_i == FMT_FULL) ? full_q : pair_q;

  // R4: upper half only changes on the falling-edge marker
  p_hi_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !half_stb_i) |=> (hi_q == $past(hi_q)));

  // R10: assembled pair untouched in full-width format
  p_full_pair_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && fmt_i == FMT_FULL) |=> (pair_q == $past(pair_q)));
endmodule

// File: rtl/ptx_shifter.sv
module ptx_shifter #(
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic              ld_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              bit_o,
  output logic              loaded_o
);
  logic [WORD_W-1:0] shift_q, shift_d;
  logic              loaded_q, loaded_d;

  always_comb begin
    shift_d  = {1'b0, shift_q[WORD_W-1:1]};
    loaded_d = loaded_q;
    if (!run_i) begin
      shift_d  = '0;
      loaded_d = 1'b0;
    end else if (ld_i) begin
      shift_d  = word_i;
      loaded_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q  <= '0;
      loaded_q <= 1'b0;
    end else begin
      shift_q  <= shift_d;
      loaded_q <= loaded_d;
    end
  end

  assign bit_o    = shift_q[0];
  assign loaded_o = loaded_q;

  // R2: a load places the captured group in the register
  p_load_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && ld_i) |=> (shift_q == $past(word_i)));

  // R6: between loads the register moves one place toward bit 0
  p_shift_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !ld_i) |=> (shift_q[WORD_W-2:0] == $past(shift_q[WORD_W-1:1])));

  // R7: the loaded flag rises only after a load
  p_loaded_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(loaded_q) |-> $past(ld_i && run_i));
endmodule

// File: rtl/ptx_outctl.sv
module ptx_outctl (
  input  logic en_i,
  input  logic loop_en_i,
  input  logic loaded_i,
  input  logic bit_i,
  output logic ser_dat_o,
  output logic ser_oe_o,
  output logic loop_dat_o
);
  logic drive_ext;
  logic drive_int;

  always_comb begin
    drive_ext  = en_i && !loop_en_i && loaded_i;
    drive_int  = en_i && loop_en_i;
    ser_oe_o   = drive_ext;
    ser_dat_o  = drive_ext && bit_i;
    loop_dat_o = drive_int && bit_i;
  end
endmodule

// File: rtl/pser_tx.sv
module pser_tx
  import ptx_pkg::*;
#(
  parameter int WORD_W      = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              fmt_sel,
  input  logic              loop_en,
  input  logic              word_stb,
  input  logic              half_stb,
  input  logic [WORD_W-1:0] td,
  output logic              ser_dat,
  output logic              ser_oe,
  output logic              loop_dat
);
  logic [SYNC_STAGES-1:0] rsync_q;
  logic                   rst_core_n;
  fmt_e                   fmt;
  logic [WORD_W-1:0]      cap_word;
  logic                   sh_bit;
  logic                   sh_loaded;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_core_n = rsync_q[SYNC_STAGES-1];

  assign fmt = fmt_e'(fmt_sel);

  ptx_capture #(.WORD_W(WORD_W)) u_capture (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .run_i      (en),
    .fmt_i      (fmt),
    .word_stb_i (word_stb),
    .half_stb_i (half_stb),
    .td_i       (td),
    .word_o     (cap_word)
  );

  ptx_shifter #(.WORD_W(WORD_W)) u_shifter (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .run_i    (en),
    .ld_i     (word_stb),
    .word_i   (cap_word),
    .bit_o    (sh_bit),
    .loaded_o (sh_loaded)
  );

  ptx_outctl u_outctl (
    .en_i       (en),
    .loop_en_i  (loop_en),
    .loaded_i   (sh_loaded),
    .bit_i      (sh_bit),
    .ser_dat_o  (ser_dat),
    .ser_oe_o   (ser_oe),
    .loop_dat_o (loop_dat)
  );

  // input rule: edge markers never coincide
  p_stb_excl: assert property (@(posedge clk) disable iff (!rst_core_n)
    !(word_stb && half_stb));

  // R8: loopback keeps the external line quiet
  p_loop_quiet_r8: assert property (@(posedge clk) disable iff (!rst_core_n)
    loop_en |-> (!ser_oe && !ser_dat));

  // R9: idle releases every output and clears the load flag by next cycle
  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_core_n)
    !en |=> (!ser_oe && !loop_dat && !ser_dat));
endmodule

// File: tb/pser_tx_tb.sv
`timescale 1ns/1ps
module pser_tx_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       en, fmt_sel, loop_en, word_stb, half_stb;
  logic [9:0] td;
  logic       ser_dat, ser_oe, loop_dat;

  int n_chk  = 0;
  int n_fail = 0;
  int fr     = 0;
  int pstart = 0;
  int lat    = 1;
  bit done   = 0;
  logic [9:0] hist [0:1023];

  always #4 clk = ~clk;

  pser_tx u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .fmt_sel(fmt_sel), .loop_en(loop_en),
    .word_stb(word_stb), .half_stb(half_stb), .td(td),
    .ser_dat(ser_dat), .ser_oe(ser_oe), .loop_dat(loop_dat)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b (frame %0d)", tag, act, exp, fr);
    end
  endtask

  function automatic int lat_of(input logic f);
    return f ? 2 : 1;
  endfunction

  // One reference period: strobe at phase 0, half strobe at phase 5.
  task automatic frame(input logic [9:0] w);
    logic exp;
    hist[fr] = w;
    for (int p = 0; p < 10; p++) begin
      @(negedge clk);
      word_stb = (p == 0);
      half_stb = (p == 5);
      td = 10'($urandom);
      if (p == 0 && !fmt_sel) td = w;
      if (p == 0 &&  fmt_sel) td[4:0] = w[4:0];
      if (p == 5 &&  fmt_sel) td[4:0] = w[9:5];
      @(posedge clk); #2;
      if (en && fr - lat >= pstart) begin
        exp = hist[fr - lat][p];
        if (loop_en) begin
          chk("R8 loop_dat", loop_dat, exp);
          chk("R8 ser_oe", ser_oe, 1'b0);
          chk("R8 ser_dat", ser_dat, 1'b0);
        end else begin
          // lat 1: bit p after edge 10+p (R2, R3); lat 2: edge 20+p (R5)
          chk(fmt_sel ? "R4 R5 ser_dat" : (p == 9 ? "R3 ser_dat" : "R2 R10 ser_dat"),
              ser_dat, exp);
          chk("R7 ser_oe", ser_oe, 1'b1);
          chk("R8 loop_dat", loop_dat, 1'b0);
        end
      end else if (!en) begin
        chk("R9 ser_oe", ser_oe, 1'b0);
        chk("R9 ser_dat", ser_dat, 1'b0);
        chk("R9 loop_dat", loop_dat, 1'b0);
      end
    end
    fr++;
  endtask

  task automatic gap(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      word_stb = 1'b0; half_stb = 1'b0; td = 10'($urandom);
      @(posedge clk); #2;
      chk("R6 ser_dat", ser_dat, 1'b0);
      chk("R6 ser_oe", ser_oe, 1'b1);
    end
  endtask

  task automatic new_phase(input logic f, input logic lp);
    fmt_sel = f;
    loop_en = lp;
    lat     = lat_of(f);
    pstart  = fr;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h0051_7EED));
    rst_n = 1'b0; en = 1'b1; fmt_sel = 1'b0; loop_en = 1'b0;
    word_stb = 1'b0; half_stb = 1'b0; td = '0;
    repeat (5) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    chk("R1 ser_oe", ser_oe, 1'b0);
    chk("R1 ser_dat", ser_dat, 1'b0);
    chk("R1 loop_dat", loop_dat, 1'b0);

    // full-width format: directed then random
    new_phase(1'b0, 1'b0);
    frame(10'h17C); frame(10'h3FF); frame(10'h000); frame(10'h2AA);
    frame(10'h001); frame(10'h200); frame(10'h155);
    for (int i = 0; i < 30; i++) frame(10'($urandom));
    frame(10'h3FF);
    frame(10'h0F0);
    gap(4);

    // half-width format
    new_phase(1'b1, 1'b0);
    frame(10'h3E0); frame(10'h01F); frame(10'h17C); frame(10'h3FF);
    frame(10'h000); frame(10'h201);
    for (int i = 0; i < 30; i++) frame(10'($urandom));

    // loopback in both formats
    new_phase(1'b1, 1'b1);
    for (int i = 0; i < 12; i++) frame(10'($urandom));
    new_phase(1'b0, 1'b1);
    for (int i = 0; i < 12; i++) frame(10'($urandom));
    new_phase(1'b0, 1'b0);
    for (int i = 0; i < 8; i++) frame(10'($urandom));

    // idle and re-enable
    @(negedge clk) en = 1'b0;
    for (int i = 0; i < 3; i++) frame(10'($urandom));
    @(negedge clk);
    en = 1'b1; word_stb = 1'b0; half_stb = 1'b0;
    @(posedge clk); #2;
    chk("R7 R9 ser_oe after re-enable", ser_oe, 1'b0);
    new_phase(1'b0, 1'b0);
    for (int i = 0; i < 10; i++) frame(10'($urandom));
    new_phase(1'b1, 1'b0);
    for (int i = 0; i < 10; i++) frame(10'($urandom));

    finish_run();
  end
endmodule